// File: doc/BRIEF.md
# External Bus Cycle Wait-State Timer

This block sets the length of each external bus cycle. The requester presents a cycle request with these inputs:

- a direction,
- the chip-select index the cycle targets,
- a 2-bit wait-state setting,
- a flag saying whether the bus is demultiplexed,
- a deferred-mode enable.

The timer raises a busy flag and opens a data-strobe window. The window lasts one base state plus the programmed wait states. At the last programmed state the timer samples the ready input, and it holds the window open for as long as ready is low. When the window closes, a one-clock completion pulse marks the end of the cycle.

On a demultiplexed bus with deferred mode on, the timer can insert a fixed two-clock gap before the strobe window opens. It does this on the first cycle that targets a different chip select than the cycle before it, and on the first cycle that reverses the read/write direction. Each clock counts as one state time. The timer remembers the chip select and direction of the last accepted cycle. After reset that memory is marked empty, so the first cycle is never deferred. Address and data handling live elsewhere.

Top module: `busCycleTimer`

## Requirements
- R1: The wait field `waitCfg` encodes 00, 01, 10 and 11 as 0, 1, 2 and 3 wait states. With `readyIn` high at the sampling point, `strobe` stays high for exactly 1 + waitCfg clocks.
- R2: `readyIn` is sampled in each strobe clock from the last programmed wait state onward, or from the base state when there are zero wait states. Each sample taken low adds one more strobe clock.
- R3: `readyIn` is ignored in strobe clocks before the last programmed wait state. Holding it low there does not lengthen the window.
- R4: With `demuxBus` and `deferEn` both high, a request whose chip-select index differs from the previous accepted cycle gets exactly 2 clocks of `busy` high with `strobe` low before the strobe window.
- R5: Under the same conditions, a request whose `reqWrite` (1 = write, 0 = read) differs from the previous accepted cycle also gets the 2-clock gap. A request that changes both the chip select and the direction gets only one gap of 2 clocks.
- R6: When `demuxBus` or `deferEn` is low, no gap is inserted. The strobe opens in the clock right after acceptance. The remembered chip select and direction are still updated.
- R7: The first cycle after reset is never deferred. A cycle with the same chip select and direction as the previous accepted cycle is never deferred.
- R8: A request is accepted only on a clock edge where `reqValid` is high and `busy` is low. `busy` is high from the clock after acceptance until the cycle ends. A request raised while busy changes neither the current cycle nor the remembered chip select and direction.
- R9: `cycleDone` is high for exactly one clock, in the clock right after the last strobe clock. In that clock `busy` and `strobe` are low.
- R10: While reset is asserted, `busy`, `strobe` and `cycleDone` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one state time per period |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Cycle request |
| reqWrite | input | 1 | Direction of the requested cycle, 1 = write |
| reqCs | input | CS_W | Chip-select index of the requested cycle |
| waitCfg | input | WAIT_W | Programmed wait-state count |
| demuxBus | input | 1 | Bus runs demultiplexed |
| deferEn | input | 1 | Deferred-cycle mode enable |
| readyIn | input | 1 | Ready from the addressed device, high = ready |
| busy | output | 1 | A cycle is in progress |
| strobe | output | 1 | Data-strobe window |
| cycleDone | output | 1 | One-clock pulse at the end of a cycle |

## Verification
If the remembered chip select or direction were wrong, a later cycle would show a 2-clock gap that should not be there, or would lack one that should. This appears in the very next cycle that follows a change or a repeat. If the state counter were wrong, the strobe window would be too long or too short. A wrong ready-sampling point would let ready stretch the window from an early wait state. Both faults appear within the cycle in which they happen. The vectors mix chip-select changes, direction reversals and both at once, and they place ready low both before and at the sampling point. This way each of these faults moves a counted gap or window length.

// File: rtl/busTimerPkg.sv
package busTimerPkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_DEFER  = 2'd1,
    PH_STROBE = 2'd2
  } phase_t;

  // strobes from control to datapath
  typedef struct packed {
    logic accept;     // capture request and history
    logic loadDefer;  // load counter with gap length
    logic loadWait;   // load counter with wait-state count
    logic countDown;  // decrement counter
  } ctrl_t;
endpackage

// File: rtl/busTimerPath.sv
module busTimerPath
  import busTimerPkg::*;
#(
  parameter int CS_W = 2,
  parameter int WAIT_W = 2,
  parameter int DEFER_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrl_t             ctl,
  input  logic [CS_W-1:0]   reqCs,
  input  logic              reqWrite,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              demuxBus,
  input  logic              deferEn,
  output logic              deferNeed,
  output logic              cntZero
);
  localparam int DEF_W = (DEFER_CYCLES > 1) ? $clog2(DEFER_CYCLES) : 1;
  localparam int CNT_W = (WAIT_W > DEF_W) ? WAIT_W : DEF_W;

  logic [CS_W-1:0]   lastCs;
  logic              lastWrite;
  logic              histValid;
  logic [WAIT_W-1:0] waitHeld;
  logic [CNT_W-1:0]  cnt;
  logic [WAIT_W-1:0] waitSrc;

  // history of the last accepted cycle
  always_ff @(posedge clk) begin
    if (!rstN) begin
      lastCs    <= '0;
      lastWrite <= 1'b0;
      histValid <= 1'b0;
      waitHeld  <= '0;
    end else if (ctl.accept) begin
      lastCs    <= reqCs;
      lastWrite <= reqWrite;
      histValid <= 1'b1;
      waitHeld  <= waitCfg;
    end
  end

  // wait count comes straight from the request when loaded at acceptance
  assign waitSrc = ctl.accept ? waitCfg : waitHeld;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt <= '0;
    end else if (ctl.loadDefer) begin
      cnt <= CNT_W'(DEFER_CYCLES - 1);
    end else if (ctl.loadWait) begin
      cnt <= CNT_W'(waitSrc);
    end else if (ctl.countDown) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign cntZero   = (cnt == '0);
  assign deferNeed = demuxBus && deferEn && histValid &&
                     ((reqCs != lastCs) || (reqWrite != lastWrite));
endmodule

// File: rtl/busTimerCtrl.sv
module busTimerCtrl
  import busTimerPkg::*;
(
  input  logic  clk,
  input  logic  rstN,
  input  logic  reqValid,
  input  logic  readyIn,
  input  logic  deferNeed,
  input  logic  cntZero,
  output ctrl_t ctl,
  output logic  busy,
  output logic  strobe,
  output logic  cycleDone
);
  phase_t phase;
  phase_t phaseNext;
  logic   doneNext;

  always_comb begin
    ctl       = '0;
    phaseNext = phase;
    doneNext  = 1'b0;
    unique case (phase)
      PH_IDLE: begin
        if (reqValid) begin
          ctl.accept = 1'b1;
          if (deferNeed) begin
            ctl.loadDefer = 1'b1;
            phaseNext     = PH_DEFER;
          end else begin
            ctl.loadWait = 1'b1;
            phaseNext    = PH_STROBE;
          end
        end
      end
      PH_DEFER: begin
        if (cntZero) begin
          ctl.loadWait = 1'b1;
          phaseNext    = PH_STROBE;
        end else begin
          ctl.countDown = 1'b1;
        end
      end
      PH_STROBE: begin
        if (!cntZero) begin
          ctl.countDown = 1'b1;
        end else if (readyIn) begin
          phaseNext = PH_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: phaseNext = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cycleDone <= 1'b0;
    end else begin
      phase     <= phaseNext;
      cycleDone <= doneNext;
    end
  end

  assign busy   = (phase != PH_IDLE);
  assign strobe = (phase == PH_STROBE);
endmodule

// File: rtl/busCycleTimer.sv
module busCycleTimer
  import busTimerPkg::*;
#(
  parameter int CS_W = 2,
  parameter int WAIT_W = 2,
  parameter int DEFER_CYCLES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [CS_W-1:0]   reqCs,
  input  logic [WAIT_W-1:0] waitCfg,
  input  logic              demuxBus,
  input  logic              deferEn,
  input  logic              readyIn,
  output logic              busy,
  output logic              strobe,
  output logic              cycleDone
);
  ctrl_t ctl;
  logic  deferNeed;
  logic  cntZero;

  busTimerCtrl ctrlU (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .readyIn(readyIn),
    .deferNeed(deferNeed), .cntZero(cntZero), .ctl(ctl),
    .busy(busy), .strobe(strobe), .cycleDone(cycleDone)
  );

  busTimerPath #(.CS_W(CS_W), .WAIT_W(WAIT_W), .DEFER_CYCLES(DEFER_CYCLES)) pathU (
    .clk(clk), .rstN(rstN), .ctl(ctl), .reqCs(reqCs), .reqWrite(reqWrite),
    .waitCfg(waitCfg), .demuxBus(demuxBus), .deferEn(deferEn),
    .deferNeed(deferNeed), .cntZero(cntZero)
  );
endmodule

// File: rtl/busCycleTimerChecker.sv
module busCycleTimerChecker (
  input logic clk,
  input logic rstN,
  input logic reqValid,
  input logic demuxBus,
  input logic deferEn,
  input logic readyIn,
  input logic busy,
  input logic strobe,
  input logic cycleDone
);
  assert_strobe_in_busy_R8: assert property (@(posedge clk) disable iff (!rstN)
    strobe |-> busy);

  assert_done_after_ready_R2: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |-> ($past(strobe) && $past(readyIn) && !busy && !strobe));

  assert_done_single_R9: assert property (@(posedge clk) disable iff (!rstN)
    cycleDone |=> !cycleDone);

  assert_strobe_close_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(strobe) |-> cycleDone);

  assert_no_gap_mux_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !busy && !(demuxBus && deferEn)) |=> strobe);

  assert_gap_two_R4: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(busy) && !strobe) |=> (busy && !strobe) ##1 (busy && strobe));
endmodule

bind busCycleTimer busCycleTimerChecker chkU (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .demuxBus(demuxBus),
  .deferEn(deferEn), .readyIn(readyIn), .busy(busy), .strobe(strobe),
  .cycleDone(cycleDone)
);

// File: tb/busCycleTimer_test.sv
module busCycleTimer_test;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqWrite = 1'b0;
  logic [1:0] reqCs = '0;
  logic [1:0] waitCfg = '0;
  logic       demuxBus = 1'b0;
  logic       deferEn = 1'b0;
  logic       readyIn = 1'b1;
  logic       busy, strobe, cycleDone;

  int checks = 0;
  int fails = 0;
  int clkCount = 0;

  busCycleTimer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqCs(reqCs), .waitCfg(waitCfg), .demuxBus(demuxBus), .deferEn(deferEn),
    .readyIn(readyIn), .busy(busy), .strobe(strobe), .cycleDone(cycleDone)
  );

  always #10 clk = ~clk;  // 50 MHz

  always @(posedge clk) begin
    clkCount <= clkCount + 1;
    if (clkCount > 20000) begin
      fails = fails + 1;
      $display("FAIL watchdog: actual %0d clocks, expected fewer than 20000", clkCount);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  typedef struct packed {
    logic [1:0] cs;
    logic       wr;
    logic [1:0] w;
    logic       dm;
    logic       de;
    logic [2:0] lowCnt;
    logic [1:0] expGap;
  } vec_t;

  localparam int NVEC = 10;
  localparam vec_t VECS [NVEC] = '{
    '{2'd0, 1'b0, 2'd0, 1'b1, 1'b1, 3'd0, 2'd0},  // R7 first cycle, R1 zero waits
    '{2'd0, 1'b0, 2'd3, 1'b1, 1'b1, 3'd0, 2'd0},  // R7 repeat, R1 three waits, R3 early low
    '{2'd1, 1'b0, 2'd1, 1'b1, 1'b1, 3'd0, 2'd2},  // R4 select change
    '{2'd1, 1'b1, 2'd2, 1'b1, 1'b1, 3'd2, 2'd2},  // R5 read to write, R2 stretch
    '{2'd1, 1'b1, 2'd0, 1'b1, 1'b1, 3'd3, 2'd0},  // R2 stretch at base state
    '{2'd2, 1'b0, 2'd2, 1'b0, 1'b1, 3'd0, 2'd0},  // R6 multiplexed bus
    '{2'd3, 1'b1, 2'd1, 1'b1, 1'b0, 3'd1, 2'd0},  // R6 deferred mode off
    '{2'd3, 1'b0, 2'd0, 1'b1, 1'b1, 3'd0, 2'd2},  // R5 write to read, history kept in R6 cycle
    '{2'd0, 1'b1, 2'd3, 1'b1, 1'b1, 3'd1, 2'd2},  // R4 R5 both change, single gap
    '{2'd0, 1'b1, 2'd1, 1'b1, 1'b1, 3'd0, 2'd0}   // R7 repeat
  };

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks = checks + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic runCycle(input vec_t v, input bit poke);
    int gapSeen = 0;
    int strobeSeen = 0;
    int target;
    bit doneSeen = 0;
    target = 1 + int'(v.w) + int'(v.lowCnt);
    @(negedge clk);
    check(cycleDone == 1'b0, "R9 pulse lasts one clock", int'(cycleDone), 0);
    reqCs = v.cs; reqWrite = v.wr; waitCfg = v.w;
    demuxBus = v.dm; deferEn = v.de; readyIn = 1'b0; reqValid = 1'b1;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 0 && poke) begin
        reqValid = 1'b1; reqCs = ~v.cs; reqWrite = ~v.wr;  // R8 request while busy
      end else begin
        reqValid = 1'b0;
      end
      if (cycleDone) begin
        doneSeen = 1;
        check(!busy && !strobe, "R9 busy and strobe low with done", int'({busy, strobe}), 0);
        break;
      end
      if (busy && !strobe) gapSeen++;
      if (strobe) strobeSeen++;
      readyIn = (strobeSeen >= target);
    end
    reqValid = 1'b0;
    check(doneSeen, "R9 cycle completes", int'(doneSeen), 1);
    check(gapSeen == int'(v.expGap), "R4 R5 R6 R7 deferred gap clocks", gapSeen, int'(v.expGap));
    check(strobeSeen == target, "R1 R2 R3 strobe window clocks", strobeSeen, target);
  endtask

  initial begin
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    check(!busy && !strobe && !cycleDone, "R10 reset state", int'({busy, strobe, cycleDone}), 0);
    rstN = 1'b1;

    foreach (VECS[k]) runCycle(VECS[k], 1'b0);

    // R8: a request raised while busy must not disturb the cycle or the history
    runCycle('{2'd0, 1'b1, 2'd2, 1'b1, 1'b1, 3'd0, 2'd0}, 1'b1);
    runCycle('{2'd0, 1'b1, 2'd1, 1'b1, 1'b1, 3'd1, 2'd0}, 1'b0);

    // R10 and R7: reset in idle, then the first cycle has no gap despite the changes
    @(negedge clk);
    rstN = 1'b0;
    readyIn = 1'b1;
    reqValid = 1'b1;
    @(negedge clk);
    check(!busy && !strobe && !cycleDone, "R10 reset ignores request",
          int'({busy, strobe, cycleDone}), 0);
    reqValid = 1'b0;
    @(negedge clk);
    rstN = 1'b1;
    runCycle('{2'd2, 1'b0, 2'd1, 1'b1, 1'b1, 3'd0, 2'd0}, 1'b0);
    runCycle('{2'd2, 1'b1, 2'd0, 1'b1, 1'b1, 3'd0, 2'd2}, 1'b0);  // R5 after reset

    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule